// File: doc/BRIEF.md
# ATA Task-File Transfer Sequencer

This block sequences programmed-I/O sector transfers for one disk channel. A host programs the task-file registers (sector count, 28-bit start address split over four bytes, drive select) through a byte-wide register port. It then writes a command byte. A read command primes the sector buffer from a storage model before the host may drain it. A write command lets the host fill the buffer first and then commits each sector. Between sectors the channel shows busy for a programmable number of cycles. At the end of every busy phase it raises an interrupt unless software has masked it.

Sector data passes through an external buffer. The block supplies the byte index for the current access (`buf_idx`). It counts data-port strobes and asks the storage side for one whole sector at a time with a request/acknowledge pair. The request carries the direction, the drive and the sector address. Five states make up the control: `IDLE`, `LOAD` (host fills the buffer), `DRAIN` (host empties the buffer), `BUSY_LD` (after a fill) and `BUSY_DR` (after a drain or priming).

The transitions are as follows:
- IDLE→LOAD on a write command.
- IDLE→BUSY_DR on a read command, which issues the priming fetch.
- LOAD→BUSY_LD on the last buffer byte.
- DRAIN→BUSY_DR on the last buffer byte.
- BUSY_LD→LOAD and BUSY_DR→DRAIN when sectors remain.
- Either busy state→IDLE when none remain.

Top module: `ata_xfer_seq`

## Requirements
- R1: After reset the status reads 0x40, and `intrq`, `blk_req` and `proto_err` are all 0.
- R2: Register addresses 1 to 6 (feature, count, sector, cylinder low, cylinder high, drive/head) read back the last value written. A write to address 8 goes to the control register. A read of address 8 returns status.
- R3: Status at address 7 (primary) and address 8 (alternate) is 0x40 in IDLE, 0x08 in LOAD or DRAIN, and 0x80 in either busy state.
- R4: A command byte 0x20 or 0x21 written to address 7 in IDLE starts a read. The read issues a fetch for the first sector at once and enters BUSY_DR. The number of sectors is the count register, where 0 means 256.
- R5: A command byte 0x30 or 0x31 in IDLE enters LOAD. After SECTOR_BYTES data writes, a commit of that sector is requested and the block enters BUSY_LD. `buf_idx` counts the bytes already moved in the sector.
- R6: In DRAIN, after SECTOR_BYTES data reads, the remaining count drops by one. If any sectors remain, the next sector is fetched. The block then enters BUSY_DR.
- R7: A busy state holds any pending request until it is acknowledged. It then waits `ready_delay` more cycles, plus one. It then returns to LOAD or DRAIN if sectors remain, and to IDLE otherwise. A busy phase with no request lasts `ready_delay`+1 cycles.
- R8: `blk_lba` equals {drive/head[3:0], cylinder high, cylinder low, sector} latched at the command, plus the index of the sector in the transfer. `blk_drive` is bit 4 of drive/head. `blk_wr` is 1 for a commit and 0 for a fetch.
- R9: `intrq` rises only on the cycle after a busy phase ends, and only if control bit 1 is clear.
- R10: A read of address 7 clears `intrq`. A read of address 8 leaves it set. A control write with bit 1 set clears it.
- R11: When a busy phase ends in the same cycle as a status read, the interrupt is still raised. When it ends in the same cycle as a control write with bit 1 set, the interrupt is not raised.
- R12: A command written outside IDLE, a data write outside LOAD, or a data read outside DRAIN sets the sticky `proto_err` and changes nothing else. An unknown command in IDLE is ignored and does not set `proto_err`.
- R13: `blk_req` stays high, with `blk_lba` and `blk_wr` stable, until `blk_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read side effect) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_wr | input | 1 | Data-port write strobe, one byte |
| dp_rd | input | 1 | Data-port read strobe, one byte |
| buf_idx | output | IDX_W | Byte index within the current sector |
| ready_delay | input | DELAY_W | Busy delay in cycles (0 = next cycle) |
| blk_req | output | 1 | Sector request to the storage side |
| blk_wr | output | 1 | Request direction: 1 commit, 0 fetch |
| blk_drive | output | 1 | Drive selected for the request |
| blk_lba | output | 28 | Sector address of the request |
| blk_ack | input | 1 | Storage acknowledge |
| proto_err | output | 1 | Sticky protocol-error flag |
| intrq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same clock edge: the end of a busy phase, which raises the interrupt, and a host action that clears it. The host action is either a primary status read or a control write with bit 1 set. The bench sets an acknowledge latency of zero and a delay of zero, so the exit edge of the busy phase after a one-sector write is known exactly. It places the status read, and separately the control write, in the cycle before that edge. It then judges the result by `intrq` in the following cycle: set after the read, clear after the masking write. The status byte returned by the colliding read must still be busy.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_BUSY_LD = 3'd3,
        ST_BUSY_DR = 3'd4
    } seq_state_t;

    localparam logic [3:0] A_FEAT     = 4'd1;
    localparam logic [3:0] A_COUNT    = 4'd2;
    localparam logic [3:0] A_SECT     = 4'd3;
    localparam logic [3:0] A_CYL_LO   = 4'd4;
    localparam logic [3:0] A_CYL_HI   = 4'd5;
    localparam logic [3:0] A_DRVHD    = 4'd6;
    localparam logic [3:0] A_STAT_CMD = 4'd7;
    localparam logic [3:0] A_ALT_CTRL = 4'd8;

    localparam int NUM_TF = 6;

    localparam logic [7:0] STAT_RDY = 8'h40;
    localparam logic [7:0] STAT_DRQ = 8'h08;
    localparam logic [7:0] STAT_BSY = 8'h80;

    localparam int MASK_BIT = 1;
    localparam int DRV_BIT  = 4;
    localparam int LBA_W    = 28;
    localparam int CNT_W    = 9;

endpackage

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            addr,
    input  logic [7:0]            wdata,
    output logic [NUM_TF*8-1:0]   tf_flat
);

    for (genvar i = 0; i < NUM_TF; i++) begin : g_tf
        logic [7:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= '0;
            else if (wr_en && addr == 4'(i + 1))
                r <= wdata;
        end
        assign tf_flat[i*8 +: 8] = r;
    end

endmodule

// File: rtl/ata_xfer_fsm.sv
module ata_xfer_fsm
    import ata_seq_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DELAY_W      = 16,
    localparam int IDX_W       = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_code,
    input  logic [7:0]         count_reg,
    input  logic [LBA_W-1:0]   lba_start,
    input  logic               drv_sel,
    input  logic               dp_wr,
    input  logic               dp_rd,
    input  logic [DELAY_W-1:0] ready_delay,
    input  logic               blk_ack,
    output seq_state_t         state_q,
    output logic [IDX_W-1:0]   byte_q,
    output logic               req_q,
    output logic               wr_q,
    output logic               drv_q,
    output logic [LBA_W-1:0]   blk_lba,
    output logic               done,
    output logic               err_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

    seq_state_t         state_d;
    logic [IDX_W-1:0]   byte_d;
    logic [CNT_W-1:0]   rem_q, rem_d, seq_q, seq_d, count_n;
    logic [DELAY_W-1:0] wait_q, wait_d;
    logic [LBA_W-1:0]   lba_q, lba_d;
    logic               req_d, wr_d, drv_d, is_rd_cmd, is_wr_cmd, is_busy, last_byte, bad;

    assign is_rd_cmd = (cmd_code == 8'h20) || (cmd_code == 8'h21);
    assign is_wr_cmd = (cmd_code == 8'h30) || (cmd_code == 8'h31);
    assign count_n   = (count_reg == 8'd0) ? CNT_W'(256) : CNT_W'(count_reg);
    assign is_busy   = (state_q == ST_BUSY_LD) || (state_q == ST_BUSY_DR);
    assign last_byte = (byte_q == LAST_IDX);
    assign done      = is_busy && !req_q && (wait_q == '0);
    assign bad       = (cmd_wr && state_q != ST_IDLE)
                     || (dp_wr && state_q != ST_LOAD)
                     || (dp_rd && state_q != ST_DRAIN);
    assign blk_lba   = lba_q + LBA_W'(seq_q);

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        byte_d  = byte_q;
        seq_d   = seq_q;
        req_d   = req_q;
        wr_d    = wr_q;
        wait_d  = wait_q;
        lba_d   = lba_q;
        drv_d   = drv_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr && (is_rd_cmd || is_wr_cmd)) begin
                    lba_d  = lba_start;
                    drv_d  = drv_sel;
                    seq_d  = '0;
                    byte_d = '0;
                    rem_d  = count_n;
                    if (is_rd_cmd) begin
                        state_d = ST_BUSY_DR;
                        req_d   = 1'b1;
                        wr_d    = 1'b0;
                        wait_d  = ready_delay;
                    end else begin
                        state_d = ST_LOAD;
                        wr_d    = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (dp_wr) begin
                    if (last_byte) begin
                        byte_d  = '0;
                        rem_d   = rem_q - 1'b1;
                        req_d   = 1'b1;
                        wr_d    = 1'b1;
                        wait_d  = ready_delay;
                        state_d = ST_BUSY_LD;
                    end else begin
                        byte_d = byte_q + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (dp_rd) begin
                    if (last_byte) begin
                        byte_d  = '0;
                        rem_d   = rem_q - 1'b1;
                        req_d   = (rem_q != CNT_W'(1));
                        wr_d    = 1'b0;
                        wait_d  = ready_delay;
                        state_d = ST_BUSY_DR;
                    end else begin
                        byte_d = byte_q + 1'b1;
                    end
                end
            end
            ST_BUSY_LD, ST_BUSY_DR: begin
                if (req_q) begin
                    if (blk_ack) begin
                        req_d = 1'b0;
                        seq_d = seq_q + 1'b1;
                    end
                end else if (wait_q == '0) begin
                    if (rem_q == '0)
                        state_d = ST_IDLE;
                    else
                        state_d = (state_q == ST_BUSY_LD) ? ST_LOAD : ST_DRAIN;
                end else begin
                    wait_d = wait_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            byte_q  <= '0;
            seq_q   <= '0;
            req_q   <= 1'b0;
            wr_q    <= 1'b0;
            wait_q  <= '0;
            lba_q   <= '0;
            drv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            byte_q  <= byte_d;
            seq_q   <= seq_d;
            req_q   <= req_d;
            wr_q    <= wr_d;
            wait_q  <= wait_d;
            lba_q   <= lba_d;
            drv_q   <= drv_d;
            err_q   <= err_q | bad;
        end
    end

endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic ctrl_wr,
    input  logic ctrl_mask_in,
    input  logic stat_rd,
    output logic irq_q
);

    logic mask_q, mask_eff, clr;

    assign mask_eff = ctrl_wr ? ctrl_mask_in : mask_q;
    assign clr      = stat_rd || (ctrl_wr && ctrl_mask_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (ctrl_wr)
                mask_q <= ctrl_mask_in;
            irq_q <= (done && !mask_eff) || (irq_q && !clr);
        end
    end

endmodule

// File: rtl/ata_xfer_seq.sv
module ata_xfer_seq
    import ata_seq_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DELAY_W      = 16,
    localparam int IDX_W       = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               dp_wr,
    input  logic               dp_rd,
    output logic [IDX_W-1:0]   buf_idx,
    input  logic [DELAY_W-1:0] ready_delay,
    output logic               blk_req,
    output logic               blk_wr,
    output logic               blk_drive,
    output logic [LBA_W-1:0]   blk_lba,
    input  logic               blk_ack,
    output logic               proto_err,
    output logic               intrq
);

    logic [NUM_TF*8-1:0] tf_flat;
    logic [7:0]          r_count, r_sect, r_cyl_lo, r_cyl_hi, r_drvhd, status;
    logic [2:0]          tf_sel;
    logic                cmd_wr, ctrl_wr, stat_rd, xfer_done;
    seq_state_t          cur_state;

    assign cmd_wr   = reg_wr && (reg_addr == A_STAT_CMD);
    assign ctrl_wr  = reg_wr && (reg_addr == A_ALT_CTRL);
    assign stat_rd  = reg_rd && (reg_addr == A_STAT_CMD);
    assign r_count  = tf_flat[(A_COUNT  - 1)*8 +: 8];
    assign r_sect   = tf_flat[(A_SECT   - 1)*8 +: 8];
    assign r_cyl_lo = tf_flat[(A_CYL_LO - 1)*8 +: 8];
    assign r_cyl_hi = tf_flat[(A_CYL_HI - 1)*8 +: 8];
    assign r_drvhd  = tf_flat[(A_DRVHD  - 1)*8 +: 8];
    assign tf_sel   = 3'(reg_addr - 4'd1);

    ata_taskfile u_tf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .tf_flat (tf_flat)
    );

    ata_xfer_fsm #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .DELAY_W      (DELAY_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_code    (reg_wdata),
        .count_reg   (r_count),
        .lba_start   ({r_drvhd[3:0], r_cyl_hi, r_cyl_lo, r_sect}),
        .drv_sel     (r_drvhd[DRV_BIT]),
        .dp_wr       (dp_wr),
        .dp_rd       (dp_rd),
        .ready_delay (ready_delay),
        .blk_ack     (blk_ack),
        .state_q     (cur_state),
        .byte_q      (buf_idx),
        .req_q       (blk_req),
        .wr_q        (blk_wr),
        .drv_q       (blk_drive),
        .blk_lba     (blk_lba),
        .done        (xfer_done),
        .err_q       (proto_err)
    );

    ata_irq_ctl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .done         (xfer_done),
        .ctrl_wr      (ctrl_wr),
        .ctrl_mask_in (reg_wdata[MASK_BIT]),
        .stat_rd      (stat_rd),
        .irq_q        (intrq)
    );

    always_comb begin
        unique case (cur_state)
            ST_LOAD, ST_DRAIN:     status = STAT_DRQ;
            ST_BUSY_LD, ST_BUSY_DR: status = STAT_BSY;
            default:               status = STAT_RDY;
        endcase
    end

    always_comb begin
        if (reg_addr >= A_FEAT && reg_addr <= A_DRVHD)
            reg_rdata = tf_flat[{tf_sel, 3'b000} +: 8];
        else if (reg_addr == A_STAT_CMD || reg_addr == A_ALT_CTRL)
            reg_rdata = status;
        else
            reg_rdata = 8'h00;
    end

endmodule

// File: rtl/ata_xfer_seq_chk.sv
module ata_xfer_seq_chk
    import ata_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             intrq,
    input logic             blk_req,
    input logic             blk_ack,
    input logic             blk_wr,
    input logic [LBA_W-1:0] blk_lba,
    input logic             proto_err,
    input logic             xfer_done,
    input seq_state_t       cur_state
);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && !blk_ack) |=> (blk_req && $stable(blk_lba) && $stable(blk_wr)));

    // R7
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_req |-> (cur_state == ST_BUSY_LD || cur_state == ST_BUSY_DR));

    // R3
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT_CMD) |->
        (reg_rdata == STAT_RDY || reg_rdata == STAT_DRQ || reg_rdata == STAT_BSY));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!intrq && !xfer_done) |=> !intrq);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intrq && reg_rd && reg_addr == A_STAT_CMD && !xfer_done) |=> !intrq);

endmodule

bind ata_xfer_seq ata_xfer_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .intrq     (intrq),
    .blk_req   (blk_req),
    .blk_ack   (blk_ack),
    .blk_wr    (blk_wr),
    .blk_lba   (blk_lba),
    .proto_err (proto_err),
    .xfer_done (xfer_done),
    .cur_state (cur_state)
);

// File: tb/ata_xfer_seq_tb.sv
module ata_xfer_seq_tb;
    import ata_seq_pkg::*;

    localparam int SB = 4;
    localparam int DW = 8;
    localparam int IW = $clog2(SB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 0, reg_rd = 0, dp_wr = 0, dp_rd = 0, blk_ack = 0;
    logic [3:0]    reg_addr = 0;
    logic [7:0]    reg_wdata = 0;
    logic [DW-1:0] ready_delay = 0;
    logic [7:0]    reg_rdata;
    logic [IW-1:0] buf_idx;
    logic          blk_req, blk_wr, blk_drive, proto_err, intrq;
    logic [27:0]   blk_lba;

    int checks = 0, errors = 0;
    logic [27:0] exp_base = 0;
    logic        exp_wr = 0, exp_drv = 0;
    int          nreq = 0, ack_lat = 0;

    always #4 clk = ~clk;

    ata_xfer_seq #(.SECTOR_BYTES(SB), .DELAY_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_wr(dp_wr), .dp_rd(dp_rd), .buf_idx(buf_idx),
        .ready_delay(ready_delay), .blk_req(blk_req), .blk_wr(blk_wr),
        .blk_drive(blk_drive), .blk_lba(blk_lba), .blk_ack(blk_ack),
        .proto_err(proto_err), .intrq(intrq)
    );

    function automatic int busy_len(bit has_req, int lat, int dly);
        return has_req ? (2 + lat + dly) : (1 + dly);
    endfunction

    function automatic int sectors_of(logic [7:0] cnt);
        return (cnt == 8'd0) ? 256 : int'(cnt);
    endfunction

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // storage model: checks each request, acknowledges after ack_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && blk_req && !blk_ack) begin
                check_eq("R8 lba", blk_lba, (exp_base + 28'(nreq)));
                check_eq("R8 dir", blk_wr, exp_wr);
                check_eq("R8 drive", blk_drive, exp_drv);
                nreq++;
                repeat (ack_lat) @(negedge clk);
                blk_ack = 1'b1;
                @(negedge clk);
                blk_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic dp_op(bit rd);
        if (rd) dp_rd = 1'b1; else dp_wr = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0; dp_wr = 1'b0;
    endtask

    task automatic measure_busy(output int n, output logic [7:0] last);
        n = 0; reg_addr = A_ALT_CTRL; reg_rd = 1'b1;
        forever begin
            #1 last = reg_rdata;
            if (last != STAT_BSY) break;
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_tf(logic [27:0] lba, logic drv, logic [7:0] cnt);
        wr_reg(A_SECT, lba[7:0]);
        wr_reg(A_CYL_LO, lba[15:8]);
        wr_reg(A_CYL_HI, lba[23:16]);
        wr_reg(A_DRVHD, {3'b111, drv, lba[27:24]});
        wr_reg(A_COUNT, cnt);
        exp_base = lba; exp_drv = drv; nreq = 0;
    endtask

    task automatic run_xfer(bit rd, output int secs);
        logic [7:0] v;
        secs = 0;
        forever begin
            rd_reg(A_ALT_CTRL, v);
            if (v == STAT_RDY) break;
            if (v == STAT_DRQ) begin
                for (int b = 0; b < SB; b++) dp_op(rd);
                secs++;
            end
        end
    endtask

    initial begin
        logic [7:0]  v, d, code, cnt;
        logic [27:0] lba;
        int          n, secs;
        bit          rd, drv;
        void'($urandom(32'h5EC7_0A1B));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(A_STAT_CMD, v);
        check_eq("R1 status", v, STAT_RDY);
        check_eq("R1 intrq", intrq, 0);
        check_eq("R1 blk_req", blk_req, 0);
        check_eq("R1 proto_err", proto_err, 0);

        // R2 readback
        for (int a = 1; a <= 6; a++) begin
            d = 8'($urandom);
            wr_reg(4'(a), d);
            rd_reg(4'(a), v);
            check_eq("R2 readback", v, d);
        end

        // R12 unknown command ignored
        wr_reg(A_STAT_CMD, 8'h55);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R12 unknown cmd status", v, STAT_RDY);
        check_eq("R12 unknown cmd err", proto_err, 0);

        // R5 R7 directed write, one sector, delay 3
        set_tf(28'h1234567, 1'b1, 8'd1);
        exp_wr = 1'b1; ready_delay = 3; ack_lat = 0;
        wr_reg(A_STAT_CMD, 8'h30);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R3 R5 load status", v, STAT_DRQ);
        dp_op(0); dp_op(0);
        check_eq("R5 buf_idx", buf_idx, 2);
        dp_op(0); dp_op(0);
        measure_busy(n, v);
        check_eq("R7 busy after load", n, busy_len(1, 0, 3));
        check_eq("R7 back to idle", v, STAT_RDY);
        check_eq("R5 commits", nreq, 1);
        check_eq("R9 irq raised", intrq, 1);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R10 alt keeps irq", intrq, 1);
        rd_reg(A_STAT_CMD, v);
        check_eq("R10 status clears irq", intrq, 0);

        // R4 R6 directed read, one sector, delay 2
        set_tf(28'h0000010, 1'b0, 8'd1);
        exp_wr = 1'b0; ready_delay = 2;
        wr_reg(A_STAT_CMD, 8'h21);
        measure_busy(n, v);
        check_eq("R4 priming busy", n, busy_len(1, 0, 2));
        check_eq("R3 drain status", v, STAT_DRQ);
        check_eq("R4 priming fetch", nreq, 1);
        for (int b = 0; b < SB; b++) dp_op(1);
        measure_busy(n, v);
        check_eq("R6 R7 busy without fetch", n, busy_len(0, 0, 2));
        check_eq("R6 no extra fetch", nreq, 1);
        rd_reg(A_STAT_CMD, v);

        // R9 masked interrupt
        wr_reg(A_ALT_CTRL, 8'h02);
        set_tf(28'h0ABCDEF, 1'b0, 8'd1);
        exp_wr = 1'b1; ready_delay = 0;
        wr_reg(A_STAT_CMD, 8'h30);
        run_xfer(0, secs);
        check_eq("R9 masked irq", intrq, 0);
        wr_reg(A_ALT_CTRL, 8'h00);

        // R10 control write clears pending
        set_tf(28'h0000100, 1'b1, 8'd1);
        wr_reg(A_STAT_CMD, 8'h31);
        run_xfer(0, secs);
        check_eq("R10 irq before ctrl", intrq, 1);
        wr_reg(A_ALT_CTRL, 8'h02);
        check_eq("R10 ctrl clears irq", intrq, 0);
        wr_reg(A_ALT_CTRL, 8'h00);

        // R11 completion and status read in the same cycle
        set_tf(28'h0000200, 1'b0, 8'd1);
        ready_delay = 0; ack_lat = 0;
        wr_reg(A_STAT_CMD, 8'h31);
        for (int b = 0; b < SB; b++) dp_op(0);
        @(negedge clk);
        rd_reg(A_STAT_CMD, v);
        check_eq("R11 colliding read status", v, STAT_BSY);
        check_eq("R11 irq survives read", intrq, 1);
        rd_reg(A_STAT_CMD, v);
        check_eq("R11 idle after", v, STAT_RDY);

        // R11 completion and masking control write in the same cycle
        set_tf(28'h0000300, 1'b0, 8'd1);
        wr_reg(A_STAT_CMD, 8'h30);
        for (int b = 0; b < SB; b++) dp_op(0);
        @(negedge clk);
        wr_reg(A_ALT_CTRL, 8'h02);
        check_eq("R11 masked at completion", intrq, 0);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R11 idle after mask", v, STAT_RDY);
        wr_reg(A_ALT_CTRL, 8'h00);

        // R4 count zero means 256
        set_tf(28'h0FFFF80, 1'b1, 8'd0);
        exp_wr = 1'b1; ack_lat = 1;
        wr_reg(A_STAT_CMD, 8'h30);
        run_xfer(0, secs);
        check_eq("R4 count zero sectors", secs, sectors_of(8'd0));
        check_eq("R4 count zero commits", nreq, 256);
        rd_reg(A_STAT_CMD, v);

        // random transfers R4 R5 R6 R8
        for (int it = 0; it < 8; it++) begin
            lba = 28'($urandom);
            drv = 1'($urandom);
            cnt = 8'(1 + $urandom % 3);
            rd  = 1'($urandom);
            code = rd ? (8'h20 | 8'($urandom % 2)) : (8'h30 | 8'($urandom % 2));
            ready_delay = DW'($urandom % 4);
            ack_lat = $urandom % 3;
            set_tf(lba, drv, cnt);
            exp_wr = !rd;
            wr_reg(A_STAT_CMD, code);
            run_xfer(rd, secs);
            check_eq("R4 R5 random sectors", secs, sectors_of(cnt));
            check_eq("R6 random requests", nreq, sectors_of(cnt));
            rd_reg(A_STAT_CMD, v);
            check_eq("R3 random idle status", v, STAT_RDY);
        end
        check_eq("R12 no error on legal traffic", proto_err, 0);

        // R12 protocol errors are ignored but flagged
        set_tf(28'h0000040, 1'b0, 8'd1);
        exp_wr = 1'b1; ready_delay = 1; ack_lat = 0;
        wr_reg(A_STAT_CMD, 8'h30);
        dp_op(0);
        wr_reg(A_STAT_CMD, 8'h20);
        check_eq("R12 cmd when busy flags", proto_err, 1);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R12 cmd ignored", v, STAT_DRQ);
        dp_op(1);
        check_eq("R12 read in load ignored", buf_idx, 1);
        run_xfer(0, secs);
        check_eq("R12 one commit only", nreq, 1);
        dp_op(1);
        rd_reg(A_ALT_CTRL, v);
        check_eq("R12 read in idle ignored", v, STAT_RDY);
        check_eq("R12 flag sticky", proto_err, 1);

        summary();
    end

endmodule